// File: doc/BRIEF.md
# EDO DRAM Controller with Timed Refresh

This block lets a synchronous host drive one 4M x 4 asynchronous DRAM with extended data output. The host presents a 22-bit word address, a write flag and 4 bits of write data under a valid/ready handshake. The controller splits the address into a row part and a column part and sends them in turn over one shared address bus. It produces the row strobe, column strobe, write strobe and output enable. After an access it keeps the row open, so a later request to the same row needs only a new column strobe. Read data comes back on the host side with a one-cycle valid pulse.

A timer requests a CAS-before-RAS refresh every 15.6 us. The request is served at the next idle point, or it closes the open page. A pending refresh always goes ahead of a waiting host request. Every timing figure is a nanosecond parameter. The block rounds it up to whole clock cycles, with a minimum of one. The row/column split is also a parameter: 12+10 bits by default, or 11+11.

The state machine has eight states. **IDLE**: the row is closed; this state takes a request (goes to ACT) or starts a refresh (goes to RCAS). **ACT**: the row strobe is low and the row address is on the bus; it waits the row-to-column delay, then goes to COL. **COL**: the column strobe is low; it waits the CAS access time, captures read data, then goes to PAGE. **PAGE**: the row is open and the column strobe is high. A same-row request goes to CSET. A request to another row, or a pending refresh, goes to PRE. **CSET**: a one-cycle column setup, then COL. **PRE**: the row strobe is high for the precharge time, then IDLE. **RCAS**: the column strobe goes low with the row strobe high, then RRAS. **RRAS**: both strobes are low for the refresh low time, then PRE.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is high, the row, column and write strobes and the output enable are all high (inactive), and rd_valid is low.
- R2: The row address is the upper ROW_BITS bits of the word address, driven while the row strobe falls. The column address is the lower COL_BITS bits, driven while the column strobe falls. Both are zero-extended to the bus width.
- R3: Each read returns the last data written to that address. It comes with a rd_valid pulse exactly one cycle long, and reads complete in request order.
- R4: Writes are early writes. The write strobe goes low at least one cycle before the column strobe falls, and the output enable stays high while it does.
- R5: A request whose row equals the open row is served with a column strobe only. A burst of such requests produces a single row strobe fall.
- R6: Before every row opening, the row strobe has been high for at least the precharge time (30 ns by default). Each access to a new row opens that row.
- R7: A refresh lowers the column strobe before the row strobe, with the write strobe held high.
- R8: A refresh request is raised every REF_NS (15.6 us by default) and is served even under continuous host traffic.
- R9: The row strobe is low for at least the row-to-column delay (20 ns by default) before the column strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request taken on this edge if valid |
| req_addr | input | 22 | Word address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 4 | Read data |
| dram_ma | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 4 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 4 | Data from the DRAM |

## Verification
The bench aims at the row-hit path. A controller that reopened the row for every request would show extra row strobe falls during a same-row burst. One that confused rows would return data from the wrong row after alternating misses. Addresses at the column and row limits expose a wrong split or a missing zero-extension, because the data lands at the wrong cell. Long idle stretches and a long stream of back-to-back hits show whether refresh runs at the right rate and whether host traffic starves it. Strobe-order checks in the memory model catch a late write strobe, a too-short precharge, and a refresh that lets the write strobe drop.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ACT,
        S_COL,
        S_PAGE,
        S_CSET,
        S_PRE,
        S_RCAS,
        S_RRAS
    } edo_state_t;

    // nanoseconds to whole clock cycles, rounded up, never below one
    function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/edo_addr_split.sv
module edo_addr_split #(
    parameter int ROW_BITS = 12,
    parameter int COL_BITS = 10,
    localparam int ADDR_W  = ROW_BITS + COL_BITS,
    localparam int MA_W    = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [MA_W-1:0]   row_ma,
    output logic [MA_W-1:0]   col_ma
);
    generate
        if (ROW_BITS == MA_W) begin : g_row_full
            assign row_ma = addr[ADDR_W-1 -: ROW_BITS];
        end else begin : g_row_pad
            assign row_ma = {{(MA_W-ROW_BITS){1'b0}}, addr[ADDR_W-1 -: ROW_BITS]};
        end
        if (COL_BITS == MA_W) begin : g_col_full
            assign col_ma = addr[COL_BITS-1:0];
        end else begin : g_col_pad
            assign col_ma = {{(MA_W-COL_BITS){1'b0}}, addr[COL_BITS-1:0]};
        end
    endgenerate
endmodule

// File: rtl/edo_wait_cnt.sv
module edo_wait_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
    parameter int PERIOD = 780,
    localparam int TW    = $clog2(PERIOD + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic pending
);
    logic [TW-1:0] tmr;
    logic          tick;

    assign tick = (tmr == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr     <= TW'(PERIOD - 1);
            pending <= 1'b0;
        end else begin
            tmr <= tick ? TW'(PERIOD - 1) : tmr - 1'b1;
            if (tick)
                pending <= 1'b1;
            else if (ack)
                pending <= 1'b0;
        end
    end
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
    import edo_ctrl_pkg::*;
#(
    parameter int CLK_NS    = 20,
    parameter int T_RP_NS   = 30,
    parameter int T_RCD_NS  = 20,
    parameter int T_CAC_NS  = 15,
    parameter int T_RASR_NS = 50,
    parameter int REF_NS    = 15600,
    parameter int ROW_BITS  = 12,
    parameter int COL_BITS  = 10,
    localparam int ADDR_W   = ROW_BITS + COL_BITS,
    localparam int MA_W     = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [3:0]        req_wdata,
    output logic              rd_valid,
    output logic [3:0]        rd_data,
    output logic [MA_W-1:0]   dram_ma,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [3:0]        dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [3:0]        dram_dq_in
);
    localparam int RP_CYC   = int'(ns2cyc(T_RP_NS, CLK_NS));
    localparam int RCD_CYC  = int'(ns2cyc(T_RCD_NS, CLK_NS));
    localparam int CAC_CYC  = int'(ns2cyc(T_CAC_NS, CLK_NS));
    localparam int RASR_CYC = int'(ns2cyc(T_RASR_NS, CLK_NS));
    localparam int REF_CYC  = int'(ns2cyc(REF_NS, CLK_NS));
    localparam int CW       = $clog2(RP_CYC + RCD_CYC + CAC_CYC + RASR_CYC + 1);

    edo_state_t        state, nxt;
    logic              ld, wait_done, ref_pend, ref_ack, accept, hit;
    logic [CW-1:0]     ldv;
    logic [ADDR_W-1:0] a_q;
    logic              we_q;
    logic [3:0]        wd_q;
    logic [MA_W-1:0]   row_ma, col_ma;

    edo_wait_cnt #(.W(CW)) u_wait (
        .clk(clk), .rst(rst), .load(ld), .load_val(ldv), .done(wait_done)
    );

    edo_refresh_timer #(.PERIOD(REF_CYC)) u_ref (
        .clk(clk), .rst(rst), .ack(ref_ack), .pending(ref_pend)
    );

    edo_addr_split #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_split (
        .addr(a_q), .row_ma(row_ma), .col_ma(col_ma)
    );

    // the last accepted address holds the row that is open in PAGE
    assign hit       = (req_addr[ADDR_W-1 -: ROW_BITS] == a_q[ADDR_W-1 -: ROW_BITS]);
    assign req_ready = !ref_pend && ((state == S_IDLE) || (state == S_PAGE && hit));
    assign accept    = req_ready && req_valid;

    // next state and wait-counter loads
    always_comb begin
        nxt     = state;
        ld      = 1'b0;
        ldv     = '0;
        ref_ack = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (ref_pend) begin
                    nxt     = S_RCAS;
                    ref_ack = 1'b1;
                end else if (req_valid) begin
                    nxt = S_ACT;
                    ld  = 1'b1;
                    ldv = CW'(RCD_CYC - 1);
                end
            end
            S_ACT: if (wait_done) begin
                nxt = S_COL;
                ld  = 1'b1;
                ldv = CW'(CAC_CYC - 1);
            end
            S_COL:  if (wait_done) nxt = S_PAGE;
            S_PAGE: begin
                if (ref_pend || (req_valid && !hit)) begin
                    nxt = S_PRE;
                    ld  = 1'b1;
                    ldv = CW'(RP_CYC - 1);
                end else if (req_valid) begin
                    nxt = S_CSET;
                end
            end
            S_CSET: begin
                nxt = S_COL;
                ld  = 1'b1;
                ldv = CW'(CAC_CYC - 1);
            end
            S_PRE:  if (wait_done) nxt = S_IDLE;
            S_RCAS: begin
                nxt = S_RRAS;
                ld  = 1'b1;
                ldv = CW'(RASR_CYC - 1);
            end
            S_RRAS: if (wait_done) begin
                nxt = S_PRE;
                ld  = 1'b1;
                ldv = CW'(RP_CYC - 1);
            end
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    // request capture and read return
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q      <= '0;
            we_q     <= 1'b0;
            wd_q     <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (accept) begin
                a_q  <= req_addr;
                we_q <= req_we;
                wd_q <= req_wdata;
            end
            rd_valid <= (state == S_COL) && wait_done && !we_q;
            if ((state == S_COL) && wait_done && !we_q)
                rd_data <= dram_dq_in;
        end
    end

    // strobe outputs decoded from state
    always_comb begin
        dram_ras_n  = 1'b1;
        dram_cas_n  = 1'b1;
        dram_we_n   = 1'b1;
        dram_oe_n   = 1'b1;
        dram_dq_oe  = 1'b0;
        dram_dq_out = wd_q;
        dram_ma     = col_ma;
        unique case (state)
            S_IDLE, S_PRE: ;
            S_ACT: begin
                dram_ras_n = 1'b0;
                dram_ma    = row_ma;
                dram_we_n  = !we_q;
                dram_dq_oe = we_q;
            end
            S_CSET, S_COL: begin
                dram_ras_n = 1'b0;
                dram_cas_n = (state == S_CSET);
                dram_we_n  = !we_q;
                dram_oe_n  = we_q;
                dram_dq_oe = we_q;
            end
            S_PAGE: begin
                dram_ras_n = 1'b0;
                dram_oe_n  = we_q;
            end
            S_RCAS: dram_cas_n = 1'b0;
            S_RRAS: begin
                dram_ras_n = 1'b0;
                dram_cas_n = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/edo_ctrl_chk.sv
module edo_ctrl_chk #(
    parameter int RP_CYC  = 2,
    parameter int RCD_CYC = 1
) (
    input logic clk,
    input logic rst,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic oe_n,
    input logic rd_valid
);
    logic [7:0] hi_cnt, lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= 8'hFF;
            lo_cnt <= 8'h00;
        end else begin
            hi_cnt <= ras_n  ? ((hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 8'd1) : 8'd0;
            lo_cnt <= !ras_n ? ((lo_cnt == 8'hFF) ? lo_cnt : lo_cnt + 8'd1) : 8'd0;
        end
    end

    // R3
    a_r3_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R4
    a_r4_early_write: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && !ras_n && !we_n) |-> ($past(!we_n) && oe_n));

    // R6
    a_r6_precharge: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (hi_cnt >= 8'(RP_CYC)));

    // R7
    a_r7_cbr_we_high: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && !cas_n) |-> we_n);

    // R9
    a_r9_rcd: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && !ras_n) |-> (lo_cnt >= 8'(RCD_CYC)));
endmodule

bind edo_dram_ctrl edo_ctrl_chk #(.RP_CYC(RP_CYC), .RCD_CYC(RCD_CYC)) u_chk (
    .clk(clk), .rst(rst), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
    .we_n(dram_we_n), .oe_n(dram_oe_n), .rd_valid(rd_valid)
);

// File: tb/sim_edo_dram_ctrl.sv
module sim_edo_dram_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [21:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [3:0]  req_wdata = '0;
    logic        rd_valid;
    logic [3:0]  rd_data;
    logic [11:0] dram_ma;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [3:0]  dram_dq_out;
    logic [3:0]  dq_drv = '0;

    always #10 clk = ~clk;

    edo_dram_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_ma(dram_ma),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dq_drv)
    );

    int nchk = 0, nfail = 0, cyc = 0;
    bit done = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural DRAM: 12-bit row, 10-bit column, key = row*1024 + col
    logic [3:0] dmem [int];
    int  row_l = 0, col_l = 0;
    int  act_cnt = 0, ref_cnt = 0;
    int  viol_rcd = 0, viol_rp = 0, viol_ew = 0, viol_cbr = 0;
    time t_ras_rise = 0, t_ras_fall = 0, t_we_fall = 0;

    always @(posedge dram_ras_n) begin #1; t_ras_rise = $time; end
    always @(negedge dram_we_n)  begin #1; t_we_fall  = $time; end

    always @(negedge dram_ras_n) begin
        #1;
        t_ras_fall = $time;
        if (dram_cas_n) begin
            act_cnt++;
            row_l = int'(dram_ma);
            if ($time - t_ras_rise < 30) viol_rp++;          // R6
        end else begin
            ref_cnt++;
            if (!dram_we_n) viol_cbr++;                      // R7
        end
    end

    always @(negedge dram_cas_n) begin
        #1;
        if (!dram_ras_n) begin
            col_l = int'(dram_ma[9:0]);
            if (dram_ma[11:10] != 2'b00) viol_rcd++;          // column must be zero-extended (R2)
            if ($time - t_ras_fall < 20) viol_rcd++;          // R9
            if (!dram_we_n) begin
                if (($time - t_we_fall < 10) || !dram_oe_n) viol_ew++;  // R4
                dmem[row_l*1024 + col_l] = dram_dq_out;
            end else begin
                dq_drv = dmem.exists(row_l*1024 + col_l) ? dmem[row_l*1024 + col_l] : 4'h0;
            end
        end
    end

    // scoreboard
    logic [3:0] shadow [int];
    logic [3:0] exq [$];

    task automatic xfer(int a, bit w, logic [3:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a[21:0];
        req_we    = w;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        if (w) shadow[a] = d;
        else   exq.push_back(shadow[a]);
        #1 req_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exq.size() == 0) chk(0, "R3 unexpected rd_valid", 1, 0);
            else begin
                logic [3:0] e;
                e = exq.pop_front();
                chk(rd_data == e, "R3 read data", int'(rd_data), int'(e));
            end
        end
    end

    task automatic sync_refresh();
        int r0;
        r0 = ref_cnt;
        wait (ref_cnt != r0);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        int a0, r0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(dram_ras_n && dram_cas_n, "R1 ras/cas high in reset", int'({dram_ras_n, dram_cas_n}), 3);
        chk(dram_we_n && dram_oe_n, "R1 we/oe high in reset", int'({dram_we_n, dram_oe_n}), 3);
        chk(!rd_valid, "R1 rd_valid low in reset", int'(rd_valid), 0);
        rst = 1'b0;

        // R5: same-row burst opens the row once
        sync_refresh();
        a0 = act_cnt;
        for (int i = 0; i < 8; i++) xfer(5*1024 + i*37, 1'b1, 4'(i + 3));
        for (int i = 0; i < 8; i++) xfer(5*1024 + i*37, 1'b0, 4'h0);
        repeat (10) @(negedge clk);
        chk(act_cnt - a0 == 1, "R5 one activation for hit burst", act_cnt - a0, 1);

        // R6: alternating rows reopen every time
        sync_refresh();
        a0 = act_cnt;
        xfer(7*1024 + 1, 1'b1, 4'h9);
        xfer(300*1024 + 1, 1'b1, 4'h6);
        xfer(7*1024 + 1, 1'b0, 4'h0);
        xfer(300*1024 + 1, 1'b0, 4'h0);
        repeat (10) @(negedge clk);
        chk(act_cnt - a0 == 4, "R6 activation per row miss", act_cnt - a0, 4);

        // R2: address split at the limits
        sync_refresh();
        xfer(22'h3FF,    1'b1, 4'hA);
        xfer(22'h3FFC00, 1'b1, 4'h5);
        xfer(22'h3FFFFF, 1'b1, 4'hC);
        xfer(0,          1'b1, 4'h3);
        repeat (6) @(negedge clk);
        chk(dmem.exists(1023) && dmem[1023] == 4'hA, "R2 col max lands in row 0",
            dmem.exists(1023) ? int'(dmem[1023]) : -1, 10);
        chk(dmem.exists(4095*1024) && dmem[4095*1024] == 4'h5, "R2 row max lands in col 0",
            dmem.exists(4095*1024) ? int'(dmem[4095*1024]) : -1, 5);
        xfer(22'h3FF, 1'b0, 4'h0);
        xfer(22'h3FFC00, 1'b0, 4'h0);
        xfer(22'h3FFFFF, 1'b0, 4'h0);
        xfer(0, 1'b0, 4'h0);

        // R8: refresh rate while idle (2340 cycles = three periods)
        repeat (10) @(negedge clk);
        r0 = ref_cnt;
        repeat (2340) @(negedge clk);
        chk(ref_cnt - r0 >= 2 && ref_cnt - r0 <= 4, "R8 idle refresh count", ref_cnt - r0, 3);

        // R8: refresh preempts a continuous stream of row hits
        r0 = ref_cnt;
        for (int i = 0; i < 300; i++) xfer(5*1024 + (i % 8)*37, 1'b0, 4'h0);
        chk(ref_cnt - r0 >= 1, "R8 refresh under traffic", ref_cnt - r0, 1);

        repeat (20) @(negedge clk);
        chk(exq.size() == 0, "R3 all reads returned", exq.size(), 0);
        chk(viol_ew == 0, "R4 early write violations", viol_ew, 0);
        chk(viol_rp == 0, "R6 precharge violations", viol_rp, 0);
        chk(viol_cbr == 0 && ref_cnt > 0, "R7 refresh order violations", viol_cbr, 0);
        chk(viol_rcd == 0, "R9 row-to-column violations", viol_rcd, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000 && !done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end
endmodule